// File: doc/BRIEF.md
# Grid Connect and Protection Sequencer

This block decides when an inverter bridge may switch, which control terms are live, and when the bridge must be dropped off the grid. While it is disconnected, the bridge stays off, and grid sensing and oscillator tracking carry on elsewhere. A connection request is acted on only when the phase tracker reports lock and no fault is held. The bridge is then switched on at the next wrap of the oscillator table index, which marks the zero crossing. It starts with a zero duty command and only the feedforward term active. Closed-loop current control is added once a settling count of control ticks has passed. That count gives the bridge-powered current sensor time to come up.

Five measurements are compared against programmable limits: grid voltage magnitude, grid frequency window, DC bus window, output current magnitude and current-tracking error magnitude. The two current-related checks are only meaningful while the sensor is powered. If any live limit is breached, the bridge is turned off on the next clock and a fault code naming the first breach is latched. The code is released only by an explicit clear, and only when the grid and bus readings are back inside their limits.

Top module: `grid_seq_top`

## Requirements
- R1: After reset the bridge, feedforward and PI enables are low, the zero-duty flag is high and the fault code is 0; the bridge stays off while no connection is made.
- R2: With the request and lock both high, the sequencer waits. The bridge enable rises on the clock edge that samples an oscillator wrap pulse in that waiting state, and never before.
- R3: When the bridge enable rises, feedforward is on, PI is off and the zero-duty flag is high. The zero-duty flag falls after the first control tick that is sampled with the bridge on.
- R4: PI enable rises on the edge that samples the SETTLE_TICKS-th control tick (default 20) counted since the bridge came on. The count restarts from zero every time the bridge is turned off.
- R5: Any of these causes a fault in any state other than fault, and the bridge enable is low after the next clock edge: grid voltage magnitude above its limit, frequency below its low limit or above its high limit, or bus voltage below its low limit or above its high limit.
- R6: Output current magnitude above its limit and tracking error magnitude above its limit cause a fault only while PI is enabled, and are ignored in every other state.
- R7: Fault codes are: 1 grid voltage, 2 grid frequency, 3 bus voltage, 4 output current, 5 tracking error, 0 none. When several limits breach in the same cycle, the lowest code wins. Once latched, the code is kept even if other limits breach later.
- R8: A fault is left to the idle state, with the code returned to 0, only on a clock edge where the clear input is high and the grid voltage, frequency and bus readings are all within limits. Otherwise the code is held.
- R9: Dropping either the request or the lock while waiting or connected returns to idle with the bridge off and no fault code.
- R10: With the lock low, a request does not start a connection attempt, so oscillator wraps do not turn the bridge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_tick_i | input | 1 | One-cycle control-loop tick strobe (10 kHz) |
| osc_wrap_i | input | 1 | One-cycle pulse when the oscillator index wraps to zero |
| pll_lock_i | input | 1 | Phase tracker locked |
| connect_req_i | input | 1 | Request to connect (level) |
| fault_clear_i | input | 1 | Clear request for a latched fault |
| grid_v_i | input | W | Grid voltage sample, signed |
| grid_f_i | input | W | Grid frequency reading, unsigned |
| bus_v_i | input | W | DC bus voltage reading, unsigned |
| out_cur_i | input | W | Bridge output current, signed |
| trk_err_i | input | W | Current-tracking error, signed |
| lim_grid_v_i | input | W | Grid voltage magnitude limit |
| lim_f_lo_i | input | W | Lowest allowed frequency |
| lim_f_hi_i | input | W | Highest allowed frequency |
| lim_bus_lo_i | input | W | Lowest allowed bus voltage |
| lim_bus_hi_i | input | W | Highest allowed bus voltage |
| lim_cur_i | input | W | Output current magnitude limit |
| lim_err_i | input | W | Tracking error magnitude limit |
| bridge_en_o | output | 1 | Bridge switching enabled |
| ff_en_o | output | 1 | Feedforward term enabled |
| pi_en_o | output | 1 | PI current control enabled |
| zero_duty_o | output | 1 | Duty command forced to zero |
| fault_code_o | output | 3 | Latched fault code |

## Verification
The bound checker watches several rules on every cycle:
- a live breach is followed by the bridge being off one clock later;
- the bridge only switches on after a sampled wrap with lock present, entering with zero duty and feedforward only;
- PI only runs with the bridge on, and only after the full settling count of ticks, which the checker counts itself;
- a latched code holds steady until a clear is presented.

Only the bench scenarios can show the rest:
- the fault-code priority when several limits breach together;
- that a clear is refused while grid or bus readings stay out of range;
- that current and error limits are ignored before PI starts;
- that the settling count restarts after an aborted connection.

// File: rtl/grid_seq_pkg.sv
package grid_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_WAIT_ZERO = 3'd1,
    ST_FF_ONLY   = 3'd2,
    ST_FF_PI     = 3'd3,
    ST_FAULT     = 3'd4
  } seq_state_e;

  localparam int unsigned NUM_LIMITS = 5;
  localparam int unsigned CODE_W     = $clog2(NUM_LIMITS + 1);

  // breach vector index, code = index + 1, lower index wins
  localparam int unsigned LIM_GRID_V = 0;
  localparam int unsigned LIM_GRID_F = 1;
  localparam int unsigned LIM_BUS_V  = 2;
  localparam int unsigned LIM_CUR    = 3;
  localparam int unsigned LIM_ERR    = 4;
endpackage

// File: rtl/grid_seq_limits.sv
module grid_seq_limits
  import grid_seq_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic signed [W-1:0]    grid_v_i,
  input  logic        [W-1:0]    grid_f_i,
  input  logic        [W-1:0]    bus_v_i,
  input  logic signed [W-1:0]    out_cur_i,
  input  logic signed [W-1:0]    trk_err_i,
  input  logic        [W-1:0]    lim_grid_v_i,
  input  logic        [W-1:0]    lim_f_lo_i,
  input  logic        [W-1:0]    lim_f_hi_i,
  input  logic        [W-1:0]    lim_bus_lo_i,
  input  logic        [W-1:0]    lim_bus_hi_i,
  input  logic        [W-1:0]    lim_cur_i,
  input  logic        [W-1:0]    lim_err_i,
  input  logic                   sensor_live_i,
  output logic [NUM_LIMITS-1:0]  breach_o,
  output logic                   env_ok_o
);
  function automatic logic [W:0] mag(input logic [W-1:0] x);
    logic [W:0] e;
    e = {x[W-1], x};
    return x[W-1] ? (~e + 1'b1) : e;
  endfunction

  logic v_bad, f_bad, b_bad, c_bad, e_bad;

  always_comb begin
    v_bad = mag(grid_v_i) > {1'b0, lim_grid_v_i};
    f_bad = (grid_f_i < lim_f_lo_i) || (grid_f_i > lim_f_hi_i);
    b_bad = (bus_v_i < lim_bus_lo_i) || (bus_v_i > lim_bus_hi_i);
    c_bad = mag(out_cur_i) > {1'b0, lim_cur_i};
    e_bad = mag(trk_err_i) > {1'b0, lim_err_i};
  end

  always_comb begin
    breach_o             = '0;
    breach_o[LIM_GRID_V] = v_bad;
    breach_o[LIM_GRID_F] = f_bad;
    breach_o[LIM_BUS_V]  = b_bad;
    // current sensor only valid once it is powered and PI runs
    breach_o[LIM_CUR]    = c_bad & sensor_live_i;
    breach_o[LIM_ERR]    = e_bad & sensor_live_i;
  end

  assign env_ok_o = ~(v_bad | f_bad | b_bad);
endmodule

// File: rtl/grid_seq_settle.sv
module grid_seq_settle #(
  parameter int unsigned SETTLE_TICKS = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic count_en_i,
  input  logic restart_i,
  output logic any_tick_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(SETTLE_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_TICKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (restart_i)            cnt_q <= '0;
    else if (count_en_i && tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign any_tick_o = cnt_q != '0;
  assign done_o     = count_en_i && tick_i && (cnt_q == LAST);
endmodule

// File: rtl/grid_seq_fault.sv
module grid_seq_fault
  import grid_seq_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_LIMITS-1:0] breach_i,
  input  logic                  arm_i,
  input  logic                  release_i,
  output logic [CODE_W-1:0]     code_o
);
  logic [CODE_W-1:0] first_code;
  logic [CODE_W-1:0] code_q;

  always_comb begin
    first_code = '0;
    for (int i = NUM_LIMITS - 1; i >= 0; i--) begin
      if (breach_i[i]) first_code = CODE_W'(i + 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     code_q <= '0;
    else if (release_i)              code_q <= '0;
    else if (arm_i && |breach_i)     code_q <= first_code;
  end

  assign code_o = code_q;
endmodule

// File: rtl/grid_seq_fsm.sv
module grid_seq_fsm
  import grid_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       lock_i,
  input  logic       wrap_i,
  input  logic       settle_done_i,
  input  logic       trip_i,
  input  logic       clear_i,
  input  logic       env_ok_i,
  output seq_state_e state_o,
  output logic       release_o
);
  seq_state_e state_q, state_d;
  logic       go;

  assign go        = req_i & lock_i;
  assign release_o = (state_q == ST_FAULT) & clear_i & env_ok_i;

  always_comb begin
    state_d = state_q;
    if (state_q != ST_FAULT && trip_i) begin
      state_d = ST_FAULT;
    end else begin
      case (state_q)
        ST_IDLE:      if (go) state_d = ST_WAIT_ZERO;
        ST_WAIT_ZERO: if (!go) state_d = ST_IDLE;
                      else if (wrap_i) state_d = ST_FF_ONLY;
        ST_FF_ONLY:   if (!go) state_d = ST_IDLE;
                      else if (settle_done_i) state_d = ST_FF_PI;
        ST_FF_PI:     if (!go) state_d = ST_IDLE;
        ST_FAULT:     if (release_o) state_d = ST_IDLE;
        default:      state_d = ST_FAULT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/grid_seq_top.sv
module grid_seq_top
  import grid_seq_pkg::*;
#(
  parameter int unsigned W            = 16,
  parameter int unsigned SETTLE_TICKS = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_tick_i,
  input  logic              osc_wrap_i,
  input  logic              pll_lock_i,
  input  logic              connect_req_i,
  input  logic              fault_clear_i,
  input  logic [W-1:0]      grid_v_i,
  input  logic [W-1:0]      grid_f_i,
  input  logic [W-1:0]      bus_v_i,
  input  logic [W-1:0]      out_cur_i,
  input  logic [W-1:0]      trk_err_i,
  input  logic [W-1:0]      lim_grid_v_i,
  input  logic [W-1:0]      lim_f_lo_i,
  input  logic [W-1:0]      lim_f_hi_i,
  input  logic [W-1:0]      lim_bus_lo_i,
  input  logic [W-1:0]      lim_bus_hi_i,
  input  logic [W-1:0]      lim_cur_i,
  input  logic [W-1:0]      lim_err_i,
  output logic              bridge_en_o,
  output logic              ff_en_o,
  output logic              pi_en_o,
  output logic              zero_duty_o,
  output logic [CODE_W-1:0] fault_code_o
);
  seq_state_e            state_w;
  logic [NUM_LIMITS-1:0] breach_w;
  logic                  env_ok_w, release_w;
  logic                  settle_done_w, any_tick_w;
  logic                  bridge_on, ff_only, pi_on;

  assign ff_only   = state_w == ST_FF_ONLY;
  assign pi_on     = state_w == ST_FF_PI;
  assign bridge_on = ff_only | pi_on;

  grid_seq_limits #(.W(W)) limits_i (
    .grid_v_i     (grid_v_i),
    .grid_f_i     (grid_f_i),
    .bus_v_i      (bus_v_i),
    .out_cur_i    (out_cur_i),
    .trk_err_i    (trk_err_i),
    .lim_grid_v_i (lim_grid_v_i),
    .lim_f_lo_i   (lim_f_lo_i),
    .lim_f_hi_i   (lim_f_hi_i),
    .lim_bus_lo_i (lim_bus_lo_i),
    .lim_bus_hi_i (lim_bus_hi_i),
    .lim_cur_i    (lim_cur_i),
    .lim_err_i    (lim_err_i),
    .sensor_live_i(pi_on),
    .breach_o     (breach_w),
    .env_ok_o     (env_ok_w)
  );

  grid_seq_settle #(.SETTLE_TICKS(SETTLE_TICKS)) settle_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (ctrl_tick_i),
    .count_en_i(ff_only),
    .restart_i (~bridge_on),
    .any_tick_o(any_tick_w),
    .done_o    (settle_done_w)
  );

  grid_seq_fsm fsm_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (connect_req_i),
    .lock_i       (pll_lock_i),
    .wrap_i       (osc_wrap_i),
    .settle_done_i(settle_done_w),
    .trip_i       (|breach_w),
    .clear_i      (fault_clear_i),
    .env_ok_i     (env_ok_w),
    .state_o      (state_w),
    .release_o    (release_w)
  );

  grid_seq_fault fault_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .breach_i (breach_w),
    .arm_i    (state_w != ST_FAULT),
    .release_i(release_w),
    .code_o   (fault_code_o)
  );

  assign bridge_en_o = bridge_on;
  assign ff_en_o     = bridge_on;
  assign pi_en_o     = pi_on;
  // duty held at zero until feedforward has had its first tick
  assign zero_duty_o = ~bridge_on | (ff_only & ~any_tick_w);
endmodule

// File: rtl/grid_seq_chk.sv
module grid_seq_chk
  import grid_seq_pkg::*;
#(
  parameter int unsigned SETTLE_TICKS = 20
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  ctrl_tick_i,
  input logic                  osc_wrap_i,
  input logic                  pll_lock_i,
  input logic                  fault_clear_i,
  input logic [NUM_LIMITS-1:0] breach_i,
  input logic                  bridge_en_o,
  input logic                  ff_en_o,
  input logic                  pi_en_o,
  input logic                  zero_duty_o,
  input logic [CODE_W-1:0]     fault_code_o
);
  localparam int unsigned CW = $clog2(SETTLE_TICKS + 1) + 1;
  logic [CW-1:0] ticks_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                       ticks_q <= '0;
    else if (!bridge_en_o)                             ticks_q <= '0;
    else if (!pi_en_o && ctrl_tick_i && ticks_q != '1) ticks_q <= ticks_q + 1'b1;
  end

  AST_ENABLE_AFTER_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bridge_en_o) |-> $past(osc_wrap_i)); // R2
  AST_ENABLE_NEEDS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bridge_en_o) |-> $past(pll_lock_i)); // R10
  AST_ENTRY_ZERO_DUTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bridge_en_o) |-> (zero_duty_o && ff_en_o && !pi_en_o)); // R3
  AST_PI_NEEDS_BRIDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pi_en_o |-> (bridge_en_o && ff_en_o && !zero_duty_o)); // R4
  AST_PI_AFTER_SETTLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pi_en_o) |-> (ticks_q == CW'(SETTLE_TICKS))); // R4
  AST_BREACH_DROPS_BRIDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|breach_i) |=> !bridge_en_o); // R5
  AST_FAULT_BRIDGE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_code_o != '0) |-> !bridge_en_o); // R5
  AST_CODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_code_o != '0 && !fault_clear_i) |=> $stable(fault_code_o)); // R8
  AST_CODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_code_o <= CODE_W'(NUM_LIMITS)); // R7
endmodule

bind grid_seq_top grid_seq_chk #(.SETTLE_TICKS(SETTLE_TICKS)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ctrl_tick_i  (ctrl_tick_i),
  .osc_wrap_i   (osc_wrap_i),
  .pll_lock_i   (pll_lock_i),
  .fault_clear_i(fault_clear_i),
  .breach_i     (breach_w),
  .bridge_en_o  (bridge_en_o),
  .ff_en_o      (ff_en_o),
  .pi_en_o      (pi_en_o),
  .zero_duty_o  (zero_duty_o),
  .fault_code_o (fault_code_o)
);

// File: tb/grid_seq_top_tb_top.sv
module grid_seq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int SETTLE = 20;
  localparam int VMAX = 30000, FLO = 4900, FHI = 5100, BLO = 1000, BHI = 20000;
  localparam int IMAX = 2000, EMAX = 500;

  logic clk_i = 0, rst_ni = 0;
  logic tick = 0, wrap = 0, lock = 0, req = 0, clr = 0;
  logic [W-1:0] gv, gf, bv, oc, te;
  logic bridge, ff, pi, zd;
  logic [2:0] code;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  grid_seq_top #(.W(W), .SETTLE_TICKS(SETTLE)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_tick_i(tick), .osc_wrap_i(wrap),
    .pll_lock_i(lock), .connect_req_i(req), .fault_clear_i(clr),
    .grid_v_i(gv), .grid_f_i(gf), .bus_v_i(bv), .out_cur_i(oc), .trk_err_i(te),
    .lim_grid_v_i(W'(VMAX)), .lim_f_lo_i(W'(FLO)), .lim_f_hi_i(W'(FHI)),
    .lim_bus_lo_i(W'(BLO)), .lim_bus_hi_i(W'(BHI)), .lim_cur_i(W'(IMAX)),
    .lim_err_i(W'(EMAX)),
    .bridge_en_o(bridge), .ff_en_o(ff), .pi_en_o(pi), .zero_duty_o(zd),
    .fault_code_o(code)
  );

  task automatic chk(string req_s, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req_s, act, exp);
    end
  endtask

  function automatic int iabs(int x);
    return x < 0 ? -x : x;
  endfunction

  function automatic int exp_code(int v, int f, int b, int c, int e, bit pi_live);
    if (iabs(v) > VMAX) return 1;
    if (f < FLO || f > FHI) return 2;
    if (b < BLO || b > BHI) return 3;
    if (pi_live && iabs(c) > IMAX) return 4;
    if (pi_live && iabs(e) > EMAX) return 5;
    return 0;
  endfunction

  task automatic step(); @(posedge clk_i); @(negedge clk_i); endtask

  task automatic nominal();
    gv = 16'sd1000; gf = 16'd5000; bv = 16'd12000; oc = 16'sd100; te = 16'sd10;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin tick = 1; step(); tick = 0; step(); end
  endtask

  task automatic clear_fault();
    req = 0; nominal(); clr = 1; step(); clr = 0;
  endtask

  task automatic enter_ff();
    req = 1; lock = 1; step(); wrap = 1; step(); wrap = 0;
  endtask

  initial begin
    nominal();
    @(negedge clk_i); step(); step();
    rst_ni = 1; step();
    chk("R1 bridge", bridge, 0); chk("R1 ff", ff, 0); chk("R1 pi", pi, 0);
    chk("R1 zero", zd, 1); chk("R1 code", code, 0);

    // R10: wraps without lock do nothing
    req = 1; lock = 0;
    for (int i = 0; i < 3; i++) begin wrap = 1; step(); wrap = 0; step(); end
    chk("R10 no connect", bridge, 0);

    // R2: wait for wrap
    lock = 1; step(); step(); step();
    chk("R2 waits", bridge, 0);
    wrap = 1; step(); wrap = 0;
    chk("R2 enable at wrap", bridge, 1);
    chk("R3 ff", ff, 1); chk("R3 pi off", pi, 0); chk("R3 zero duty", zd, 1);
    ticks(1);
    chk("R3 zero released", zd, 0);
    ticks(SETTLE - 2);
    chk("R4 pi not yet", pi, 0);
    // R6: current/error ignored before PI
    oc = 16'sd3000; te = -16'sd900; step();
    chk("R6 ignored code", code, 0); chk("R6 bridge kept", bridge, 1);
    nominal();
    ticks(1);
    chk("R4 pi on", pi, 1); chk("R4 ff stays", ff, 1);
    oc = -16'sd2500; step();
    chk("R5 bridge off", bridge, 0); chk("R7 current code", code, 4);
    step(); chk("R8 held", code, 4);
    clear_fault(); chk("R8 cleared", code, 0);

    // R7 tracking error in PI
    enter_ff(); ticks(SETTLE); chk("R4 pi again", pi, 1);
    te = 16'sd600; step(); chk("R7 err code", code, 5); chk("R5 off", bridge, 0);
    clear_fault();

    // R5 bus high while connected
    enter_ff(); ticks(SETTLE);
    bv = 16'd25000; step(); chk("R5 bus code", code, 3); chk("R5 bridge", bridge, 0);
    gv = 16'sd31000; step(); chk("R7 first kept", code, 3);
    gv = 16'sd1000; clr = 1; step(); clr = 0;
    chk("R8 refused", code, 3);
    clear_fault(); chk("R8 cleared2", code, 0);

    // R7 simultaneous
    gv = -16'sd31000; gf = 16'd5200; step(); chk("R7 priority", code, 1);
    clear_fault();
    gf = 16'd4800; step(); chk("R5 freq low", code, 2);
    clear_fault(); chk("R8 cleared3", code, 0);

    // R9 lock loss connected, request drop while waiting
    enter_ff(); ticks(SETTLE);
    lock = 0; step(); chk("R9 off", bridge, 0); chk("R9 no code", code, 0); chk("R9 pi", pi, 0);
    lock = 1; step(); req = 0; step(); wrap = 1; step(); wrap = 0;
    chk("R9 wait abort", bridge, 0);

    // R4 counter restart
    enter_ff(); ticks(10); req = 0; step(); chk("R9 req drop", bridge, 0);
    enter_ff(); ticks(SETTLE - 1); chk("R4 restarted", pi, 0);
    ticks(1); chk("R4 full count", pi, 1);
    req = 0; step();

    // random measurements from idle
    void'($urandom(32'd7919));
    for (int n = 0; n < 300; n++) begin
      int v, f, b, c, e, x;
      v = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 65535)) - 32768
                                      : int'($urandom_range(0, 60000)) - 30000;
      f = ($urandom_range(0, 3) == 0) ? int'($urandom_range(4500, 5500))
                                      : int'($urandom_range(FLO, FHI));
      b = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 30000))
                                      : int'($urandom_range(BLO, BHI));
      c = int'($urandom_range(0, 65535)) - 32768;
      e = int'($urandom_range(0, 65535)) - 32768;
      gv = W'(v); gf = W'(f); bv = W'(b); oc = W'(c); te = W'(e);
      x = exp_code(v, f, b, c, e, 1'b0);
      step();
      chk("R7 random code", code, x);
      chk("R6 random bridge", bridge, 0);
      if (x != 0) begin clear_fault(); chk("R8 random clear", code, 0); end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule